// File: doc/BRIEF.md
# Pulsed Emitter Proximity Sequencer

This block runs an infrared emitter at a low duty cycle and reads a digitised photodetector level at two points of each emitter cycle. The first reading is taken while the emitter is still dark. The second is taken while the emitter is lit. Subtracting the dark reading from the lit reading cancels ambient light. The block compares the difference with a threshold and raises a wake-up line only when a reflecting object has been seen for a programmable number of consecutive cycles. This lets a sleeping controller stay asleep through changes in ambient light.

The sequencer is a three-state machine:
- `PH_IDLE` is the disabled or unconfigured state. The emitter is off.
- `PH_DARK` is the emitter-off part of a cycle. The dark reading is taken on its last cycle.
- `PH_LIGHT` is the emitter-on part of a cycle. The lit reading is taken once during it, and the pair is evaluated on its last cycle.

The transitions are:
- start: `PH_IDLE` to `PH_DARK` when enabled with legal settings.
- fire: `PH_DARK` to `PH_LIGHT` after the dark reading.
- wrap: `PH_LIGHT` to `PH_DARK` at the end of the cycle when the settings are still legal.
- halt: `PH_LIGHT` to `PH_IDLE` at the end of the cycle when the settings have become illegal.
- abort: `PH_DARK` or `PH_LIGHT` to `PH_IDLE` whenever enable is low.

The settings (period, on-width and settle count) are captured on entry to `PH_DARK`.

Top module: `prox_pulse_seq`

## Requirements
- R1: While `rst_n` is low, and from the cycle after `enable` is seen low, `emitter_en`, `wake` and `diff_valid` are 0 and `diff_out` is 0.
- R2: With legal settings, each emitter cycle lasts `period` clocks. In that cycle `emitter_en` is low for `period - on_width` clocks and then high for `on_width` clocks. The first cycle starts on the clock after `enable` is first sampled high.
- R3: Settings are legal only when `on_width` is nonzero and `on_width < period`. With illegal settings the emitter never turns on and no evaluation occurs.
- R4: The dark reading is `adc_level` on the last emitter-off clock. The lit reading is `adc_level` on emitter-on clock index min(`settle`, `on_width` - 1), where index 0 is the first lit clock.
- R5: `diff_out` equals the lit reading minus the dark reading, clamped to 0 when negative. It is updated with a one-clock `diff_valid` pulse on the first clock after the emitter turns off at the end of a cycle, and only then.
- R6: A cycle is a hit when the difference is strictly greater than `threshold`. `wake` rises together with `diff_valid` once the last `run_len` evaluations were all hits. A `run_len` of 0 acts as 1, and the internal hit count saturates.
- R7: `wake` falls together with the first `diff_valid` whose difference is not a hit. Between evaluations, while enabled, `wake` holds its value.
- R8: Settings are captured at the start of each emitter cycle. A change made mid-cycle takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low forces the idle state |
| adc_level | input | DATA_W | Digitised photodetector level |
| period | input | CNT_W | Emitter cycle length in clocks |
| on_width | input | CNT_W | Emitter-on clocks per cycle |
| settle | input | CNT_W | Lit clocks waited before the lit reading |
| threshold | input | DATA_W | Difference level that counts as a hit |
| run_len | input | RUN_W | Consecutive hits needed for wake |
| emitter_en | output | 1 | Emitter drive |
| diff_out | output | DATA_W | Last clamped lit-minus-dark difference |
| diff_valid | output | 1 | One-clock strobe on a new difference |
| wake | output | 1 | Object-present wake-up |

## Verification
A phase counter or state that slips shows up within one emitter cycle as an on-run or off-run of the wrong length on `emitter_en`. It also moves the `diff_valid` pulse off the clock after the emitter turns off. The detector model drives a fresh random level every clock, so a reading taken on the wrong clock corrupts `diff_out` at the very next evaluation. A hit counter that is wrong, or not cleared, shows up as `wake` rising or falling on the wrong evaluation within `run_len` cycles.

// File: rtl/prox_pkg.sv
package prox_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DARK  = 2'd1,
        PH_LIGHT = 2'd2
    } phase_t;

    // Smaller of two counter values
    function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/prox_timing_fsm.sv
module prox_timing_fsm
    import prox_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] on_width,
    input  logic [CNT_W-1:0] settle,
    output logic             emitter_en,
    output logic             dark_stb,
    output logic             light_stb,
    output logic             eval_stb
);

    phase_t           state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] p_q, w_q, s_q;
    logic             cfg_ok;
    logic             load;
    logic [CNT_W-1:0] off_last, cyc_last, w_m1, s_idx, light_idx;

    assign cfg_ok    = (on_width != '0) && (on_width < period);
    assign off_last  = p_q - w_q - 1'b1;
    assign cyc_last  = p_q - 1'b1;
    assign w_m1      = w_q - 1'b1;
    assign s_idx     = CNT_W'(umin(32'(s_q), 32'(w_m1)));
    assign light_idx = p_q - w_q + s_idx;

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE: begin
                if (enable && cfg_ok) state_nx = PH_DARK;
            end
            PH_DARK: begin
                if (!enable)              state_nx = PH_IDLE;
                else if (cnt == off_last) state_nx = PH_LIGHT;
            end
            PH_LIGHT: begin
                if (!enable)              state_nx = PH_IDLE;
                else if (cnt == cyc_last) state_nx = cfg_ok ? PH_DARK : PH_IDLE;
            end
            default: state_nx = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    assign load = (state_nx == PH_DARK) && (state != PH_DARK);

    // Phase counter and per-cycle settings capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            p_q <= '0;
            w_q <= '0;
            s_q <= '0;
        end else begin
            if (load || state_nx == PH_IDLE) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
            if (load) begin
                p_q <= period;
                w_q <= on_width;
                s_q <= settle;
            end
        end
    end

    // Outputs
    always_comb begin
        emitter_en = 1'b0;
        dark_stb   = 1'b0;
        light_stb  = 1'b0;
        eval_stb   = 1'b0;
        unique case (state)
            PH_IDLE: ;
            PH_DARK: dark_stb = enable && (cnt == off_last);
            PH_LIGHT: begin
                emitter_en = 1'b1;
                light_stb  = enable && (cnt == light_idx);
                eval_stb   = enable && (cnt == cyc_last);
            end
            default: ;
        endcase
    end

    // R1
    disabled_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !emitter_en);

    // R4
    dark_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emitter_en) |-> $past(dark_stb));

    // R3
    legal_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emitter_en) |-> (w_q != '0) && (w_q < p_q));

endmodule

// File: rtl/prox_sampler.sv
module prox_sampler #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DATA_W-1:0] adc_level,
    input  logic              dark_stb,
    input  logic              light_stb,
    input  logic              eval_stb,
    output logic [DATA_W-1:0] diff_nx,
    output logic [DATA_W-1:0] diff_q,
    output logic              diff_valid
);

    localparam int SW = DATA_W + 1;

    logic [DATA_W-1:0] dark_q, light_q, light_now;
    logic signed [SW-1:0] d_s;

    assign light_now = light_stb ? adc_level : light_q;
    assign d_s       = $signed({1'b0, light_now}) - $signed({1'b0, dark_q});
    assign diff_nx   = d_s[SW-1] ? '0 : d_s[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dark_q     <= '0;
            light_q    <= '0;
            diff_q     <= '0;
            diff_valid <= 1'b0;
        end else if (!enable) begin
            diff_q     <= '0;
            diff_valid <= 1'b0;
        end else begin
            if (dark_stb)  dark_q  <= adc_level;
            if (light_stb) light_q <= adc_level;
            if (eval_stb)  diff_q  <= diff_nx;
            diff_valid <= eval_stb;
        end
    end

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diff_valid |=> !diff_valid);

endmodule

// File: rtl/prox_wake_filter.sv
module prox_wake_filter #(
    parameter int DATA_W = 10,
    parameter int RUN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              eval_stb,
    input  logic [DATA_W-1:0] diff_nx,
    input  logic [DATA_W-1:0] threshold,
    input  logic [RUN_W-1:0]  run_len,
    output logic              wake
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_q, run_inc, need;
    logic             hit;

    assign hit     = diff_nx > threshold;
    assign need    = (run_len == '0) ? RUN_W'(1) : run_len;
    assign run_inc = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            wake  <= 1'b0;
        end else if (!enable) begin
            run_q <= '0;
            wake  <= 1'b0;
        end else if (eval_stb) begin
            if (hit) begin
                run_q <= run_inc;
                wake  <= (run_inc >= need);
            end else begin
                run_q <= '0;
                wake  <= 1'b0;
            end
        end
    end

    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_stb && enable) |=> $stable(wake));

endmodule

// File: rtl/prox_pulse_seq.sv
module prox_pulse_seq #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 10,
    parameter int RUN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DATA_W-1:0] adc_level,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  on_width,
    input  logic [CNT_W-1:0]  settle,
    input  logic [DATA_W-1:0] threshold,
    input  logic [RUN_W-1:0]  run_len,
    output logic              emitter_en,
    output logic [DATA_W-1:0] diff_out,
    output logic              diff_valid,
    output logic              wake
);

    logic              dark_stb, light_stb, eval_stb;
    logic [DATA_W-1:0] diff_nx;

    prox_timing_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .period     (period),
        .on_width   (on_width),
        .settle     (settle),
        .emitter_en (emitter_en),
        .dark_stb   (dark_stb),
        .light_stb  (light_stb),
        .eval_stb   (eval_stb)
    );

    prox_sampler #(.DATA_W(DATA_W)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .adc_level  (adc_level),
        .dark_stb   (dark_stb),
        .light_stb  (light_stb),
        .eval_stb   (eval_stb),
        .diff_nx    (diff_nx),
        .diff_q     (diff_out),
        .diff_valid (diff_valid)
    );

    prox_wake_filter #(.DATA_W(DATA_W), .RUN_W(RUN_W)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .eval_stb  (eval_stb),
        .diff_nx   (diff_nx),
        .threshold (threshold),
        .run_len   (run_len),
        .wake      (wake)
    );

    // R5
    eval_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(emitter_en) && $past(enable)) |-> diff_valid);

    // R7
    miss_drops_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_valid && (diff_out <= $past(threshold))) |-> !wake);

    // R6
    wake_on_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> diff_valid);

endmodule

// File: tb/sim_prox_pulse_seq.sv
module sim_prox_pulse_seq;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 10;
    localparam int RUN_W  = 4;
    localparam int MAXV   = (1 << DATA_W) - 1;
    localparam int LIMIT  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [DATA_W-1:0] adc_level = '0;
    logic [CNT_W-1:0]  period = 16'd8, on_width = 16'd3, settle = 16'd1;
    logic [DATA_W-1:0] threshold = '0;
    logic [RUN_W-1:0]  run_len = '0;
    logic              emitter_en, diff_valid, wake;
    logic [DATA_W-1:0] diff_out;

    always #10 clk = ~clk;

    prox_pulse_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W), .RUN_W(RUN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .adc_level(adc_level),
        .period(period), .on_width(on_width), .settle(settle),
        .threshold(threshold), .run_len(run_len),
        .emitter_en(emitter_en), .diff_out(diff_out),
        .diff_valid(diff_valid), .wake(wake)
    );

    int errors = 0, checks = 0, cycles = 0;
    int base = 100, refl = 0, invert = 0;
    int lat_p = 8, lat_w = 3, lat_s = 1;
    int prev_adc = 0, last_dark = 0, last_light = 0;
    int on_run = 0, off_run = 0, run_cnt = 0;
    logic exp_wake = 1'b0, prev_em = 1'b0, runchk = 1'b1;
    int rises = 0, evals = 0;

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sense(input logic em);
        int v = base + int'($urandom % 4);
        if ((em && invert == 0) || (!em && invert != 0)) v += refl;
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic int clamp0(input int v);
        return (v < 0) ? 0 : v;
    endfunction

    task automatic tick();
        int ed, need, idx;
        logic fall, rise;
        @(negedge clk);
        cycles++;
        if (cycles > LIMIT) begin
            check("watchdog", 1'b0, cycles, LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        fall = prev_em && !emitter_en;
        rise = !prev_em && emitter_en;
        if (fall && enable) begin
            evals++;
            ed = clamp0(last_light - last_dark);
            check("R5 diff_valid on cycle wrap", diff_valid, int'(diff_valid), 1);
            check("R4 R5 clamped difference", diff_out == DATA_W'(ed), int'(diff_out), ed);
            if (ed > int'(threshold)) run_cnt = (run_cnt == 15) ? 15 : run_cnt + 1;
            else run_cnt = 0;
            need = (run_len == 0) ? 1 : int'(run_len);
            exp_wake = (ed > int'(threshold)) && (run_cnt >= need);
            check(exp_wake ? "R6 wake after hits" : "R7 wake low on miss",
                  wake == exp_wake, int'(wake), int'(exp_wake));
            if (runchk) check("R2 R8 on-run length", on_run == lat_w, on_run, lat_w);
            lat_p = int'(period); lat_w = int'(on_width); lat_s = int'(settle);
        end else if (diff_valid) begin
            check("R5 stray diff_valid", 1'b0, 1, 0);
        end
        if (!enable) begin
            exp_wake = 1'b0;
            run_cnt  = 0;
        end
        if (wake != exp_wake) check("R7 wake hold", 1'b0, int'(wake), int'(exp_wake));
        if (rise) begin
            rises++;
            last_dark = prev_adc;
            if (runchk) check("R2 R8 off-run length", off_run == lat_p - lat_w, off_run, lat_p - lat_w);
        end
        if (!emitter_en) on_run = 0;
        if (!enable) off_run = 0;
        else if (!emitter_en) off_run++;
        else off_run = 0;
        adc_level = DATA_W'(sense(emitter_en));
        if (emitter_en) begin
            idx = (lat_s < lat_w - 1) ? lat_s : lat_w - 1;
            if (on_run == idx) last_light = int'(adc_level);
            on_run++;
        end
        prev_adc = int'(adc_level);
        prev_em  = emitter_en;
    endtask

    task automatic start(input int p, input int w, input int s);
        enable = 1'b0;
        tick();
        tick();
        period = CNT_W'(p); on_width = CNT_W'(w); settle = CNT_W'(s);
        lat_p = p; lat_w = w; lat_s = s;
        enable = 1'b1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 reset emitter", emitter_en == 1'b0, int'(emitter_en), 0);
        check("R1 reset wake", wake == 1'b0, int'(wake), 0);
        check("R1 reset diff", diff_out == '0 && !diff_valid, int'(diff_out), 0);
        rst_n = 1'b1;

        // R3 illegal settings: zero width, then width equal to period
        runchk = 1'b0;
        start(6, 0, 0);
        rises = 0; evals = 0;
        run(40);
        check("R3 zero width no fire", rises == 0 && evals == 0, rises, 0);
        start(6, 6, 0);
        rises = 0; evals = 0;
        run(40);
        check("R3 width=period no fire", rises == 0 && evals == 0, rises, 0);
        runchk = 1'b1;

        // R6 three hits needed, strong reflection
        threshold = 10'd20; run_len = 4'd3; base = 100; refl = 60; invert = 0;
        start(8, 3, 1);
        run(8 * 6);
        check("R6 wake after three hits", wake == 1'b1, int'(wake), 1);
        // R7 reflection gone: first miss drops wake
        refl = 0;
        run(8 * 3);
        check("R7 wake dropped", wake == 1'b0, int'(wake), 0);
        // R5 lit level below dark level clamps to zero
        invert = 1; refl = 50;
        run(8 * 3);
        check("R5 negative clamps", diff_out == '0, int'(diff_out), 0);
        invert = 0;

        // R6 run_len zero acts as one; settle beyond width
        run_len = 4'd0; refl = 80;
        start(10, 4, 9);
        run(10 * 2 + 2);
        check("R6 run_len zero acts as one", wake == 1'b1, int'(wake), 1);

        // R8 change width mid-cycle while emitter is lit
        while (!emitter_en) tick();
        on_width = 16'd6; settle = 16'd2;
        run(10 * 4);

        // R1 disable while lit
        while (!emitter_en) tick();
        enable = 1'b0;
        tick();
        check("R1 disable forces emitter off", emitter_en == 1'b0, int'(emitter_en), 0);
        check("R1 disable clears wake", wake == 1'b0 && diff_out == '0, int'(wake), 0);

        // Random settings and scenes
        for (int r = 0; r < 40; r++) begin
            int p, w, s;
            p = 2 + int'($urandom % 14);
            w = 1 + int'($urandom % (p - 1));
            s = int'($urandom % (w + 2));
            threshold = DATA_W'(int'($urandom % 60));
            run_len   = RUN_W'(int'($urandom % 4));
            base      = int'($urandom % 900);
            refl      = int'($urandom % 120);
            invert    = (($urandom % 5) == 0) ? 1 : 0;
            start(p, w, s);
            run(p * (3 + int'($urandom % 5)));
        end

        enable = 1'b0;
        run(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule